// File: doc/BRIEF.md
# Protected SMM Memory Window Controller

This block decides where each processor memory access is sent while protected system-management memory is in use. It holds two byte-wide control registers: a window control byte and an extended window byte. From these registers, the access address and the processor's management-mode flag, it picks one routing target. The targets are the legacy video/PCI space, DRAM through the low legacy segment, DRAM through a high alias, DRAM inside the protected top-of-low-memory segment, a discard sink, or plain pass-through to the normal address decoder.

Configuration software writes the registers through a 16-bit port with one enable per byte. Byte 0 is the window control byte and byte 1 is the extended byte. A lock bit freezes the security-relevant fields until reset. The protected segment (called TSEG below) ends at the top of low memory. Its size comes from a 2-bit code or from an extended megabyte count set at build time. The route code is combinational: any change to the registers applies to the very next access.

Top module: `smm_window_ctrl`

## Requirements
- R1: After synchronous reset both registers read 0x00 on `cfg_rdata`, and a non-management access to the legacy segment (0xA0000 to 0xBFFFF) routes to code 1 (legacy video/PCI). Route codes: 0 pass-through, 1 legacy video/PCI, 2 low-segment DRAM, 3 high-alias DRAM, 4 TSEG DRAM, 5 discard sink.
- R2: Before the lock is set, the window control byte has only bits [2:0] writable: bit0 global enable, bit1 open, bit2 lock. Bits [7:3] always read 0. The extended byte is writable in full: bit0 TSEG enable, bits[2:1] size code, bit3 high enable, bits[7:4] spare. A byte changes only when `cfg_wr` is high and its `cfg_be` bit is set.
- R3: A write that sets the lock bit also clears the open bit in the same write. After that, the window control byte cannot be changed and extended bits [3:0] cannot be changed, while extended bits [7:4] stay writable. This holds until reset.
- R4: A non-management access with open=1 and high enable=0 routes legacy-segment addresses to code 2. With open=1 and high enable=1, legacy-segment addresses route to code 1 and high-alias addresses (0xFEDA0000 to 0xFEDBFFFF) route to code 3.
- R5: A non-management access with open=0 routes legacy-segment addresses to code 1 and high-alias addresses to code 0.
- R6: A management access with global enable=1 routes the legacy segment to code 2 if high enable=0, and routes the high alias to code 3 if high enable=1. A management access that no management window covers is routed exactly as a non-management access would be.
- R7: TSEG is active only when both TSEG enable and global enable are 1. Size code 0 selects 1 MiB, 1 selects 2 MiB, 2 selects 8 MiB, and 3 selects the extended megabyte count.
- R8: An active TSEG covers [top of low memory − size, top of low memory). Management accesses inside this range route to code 4. The addresses one below the base and at the top route to code 0.
- R9: Non-management accesses inside an active TSEG route to code 5. The sink returns all-ones read data and drops writes.
- R10: When the extended megabyte count is zero, size code 3 leaves TSEG inactive.
- R11: A register write accepted at a clock edge changes the route code of accesses presented right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 2 | Byte enables: bit0 window control byte, bit1 extended byte |
| cfg_wdata | input | 16 | Write data, byte 0 in [7:0], byte 1 in [15:8] |
| cfg_rdata | output | 16 | Current register contents, same layout as write data |
| acc_addr | input | 32 | Address of the current memory access |
| acc_smm | input | 1 | High when the access is made in management mode |
| acc_route | output | 3 | Route code for the current access |

## Verification
A wrong register bit shows up on `cfg_rdata` in the cycle after the write that corrupted it. It also changes `acc_route` for the very next access, because routing has no pipeline stage. A lock that fails to stick, or a mask that is too wide, appears as a changed read-back in the cycle after a write that should have been refused. A wrong TSEG size or base moves the point where the route switches, which the base−1, base, top−1 and top probes reveal at once. A mixed-up management or open decode shows as the wrong code in a specific mode, such as sink instead of TSEG, or legacy instead of low DRAM.

// File: rtl/smm_win_pkg.sv
package smm_win_pkg;

    localparam int unsigned REG_BYTES = 2;

    typedef enum logic [2:0] {
        RT_PASS   = 3'd0,
        RT_LEGACY = 3'd1,
        RT_LOWMEM = 3'd2,
        RT_HIGHAL = 3'd3,
        RT_TSEG   = 3'd4,
        RT_SINK   = 3'd5
    } route_e;

    // window control byte
    typedef struct packed {
        logic [4:0] rsvd;
        logic       lock;
        logic       open;
        logic       glb;
    } winctl_t;

    // extended byte
    typedef struct packed {
        logic [3:0] spare;
        logic       hi_en;
        logic [1:0] sz_code;
        logic       tseg_en;
    } winext_t;

    localparam logic [7:0] CTL_DEFAULT  = 8'h00;
    localparam logic [7:0] EXT_DEFAULT  = 8'h00;
    localparam logic [7:0] CTL_MASK_OPEN = 8'h07;
    localparam logic [7:0] EXT_MASK_OPEN = 8'hFF;
    localparam logic [7:0] CTL_MASK_LOCK = 8'h00;
    localparam logic [7:0] EXT_MASK_LOCK = 8'hF0;

    function automatic logic [31:0] tseg_size_bytes(input logic [1:0] code,
                                                    input logic [31:0] ext_mb);
        logic [31:0] r;
        case (code)
            2'd0:    r = 32'h0010_0000;
            2'd1:    r = 32'h0020_0000;
            2'd2:    r = 32'h0080_0000;
            default: r = ext_mb << 20;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/smm_cfg_regs.sv
module smm_cfg_regs
    import smm_win_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr,
    input  logic [REG_BYTES-1:0]   be,
    input  logic [REG_BYTES*8-1:0] wdata,
    output logic [REG_BYTES*8-1:0] regs
);
    localparam int unsigned W = REG_BYTES * 8;

    logic [W-1:0] cur, merged, msk, nxt;
    winctl_t      ctl_cur, ctl_nxt;

    assign ctl_cur = winctl_t'(cur[7:0]);
    assign msk = ctl_cur.lock ? {EXT_MASK_LOCK, CTL_MASK_LOCK}
                              : {EXT_MASK_OPEN, CTL_MASK_OPEN};

    for (genvar b = 0; b < REG_BYTES; b++) begin : g_byte
        assign merged[b*8 +: 8] = (wr && be[b])
            ? ((cur[b*8 +: 8] & ~msk[b*8 +: 8]) | (wdata[b*8 +: 8] & msk[b*8 +: 8]))
            : cur[b*8 +: 8];
    end

    always_comb begin
        ctl_nxt = winctl_t'(merged[7:0]);
        if (ctl_nxt.lock) ctl_nxt.open = 1'b0;
        nxt = {merged[W-1:8], ctl_nxt};
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= {EXT_DEFAULT, CTL_DEFAULT};
        else     cur <= nxt;
    end

    assign regs = cur;

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_cur.lock |=> ctl_cur.lock);
    // R3
    locked_ctl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_cur.lock |=> ($stable(cur[7:0]) && $stable(cur[11:8])));
    // R3
    lock_clears_open_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_cur.lock |-> !ctl_cur.open);
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_cur.rsvd == 5'd0);
    // R2
    no_enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cur));

endmodule

// File: rtl/smm_tseg_window.sv
module smm_tseg_window
    import smm_win_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] TOP_LOW_MEM = 32'h8000_0000,
    parameter int unsigned       EXT_MB      = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              glb,
    input  logic              tseg_en,
    input  logic [1:0]        sz_code,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_tseg
);
    localparam logic [31:0] EXT_MB_V = 32'(EXT_MB);

    logic [ADDR_W-1:0] size_b, base_a;
    logic              active;

    assign size_b  = ADDR_W'(tseg_size_bytes(sz_code, EXT_MB_V));
    assign base_a  = TOP_LOW_MEM - size_b;
    assign active  = glb && tseg_en && (size_b != '0);
    assign in_tseg = active && (addr >= base_a) && (addr < TOP_LOW_MEM);

    // R7
    tseg_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
        in_tseg |-> (glb && tseg_en));
    // R10
    zero_ext_off_chk: assert property (@(posedge clk) disable iff (rst)
        (sz_code == 2'd3 && EXT_MB_V == 32'd0) |-> !in_tseg);
    // R8
    below_top_chk: assert property (@(posedge clk) disable iff (rst)
        in_tseg |-> (addr < TOP_LOW_MEM));

endmodule

// File: rtl/smm_route_decode.sv
module smm_route_decode
    import smm_win_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] LEG_BASE   = 32'h000A_0000,
    parameter logic [ADDR_W-1:0] HIGH_BASE  = 32'hFEDA_0000,
    parameter logic [ADDR_W-1:0] SEG_BYTES  = 32'h0002_0000
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              glb,
    input  logic              open,
    input  logic              hi_en,
    input  logic              smm,
    input  logic              in_tseg,
    input  logic [ADDR_W-1:0] addr,
    output route_e            route
);
    localparam logic [ADDR_W-1:0] LEG_END  = LEG_BASE + SEG_BYTES;
    localparam logic [ADDR_W-1:0] HIGH_END = HIGH_BASE + SEG_BYTES;

    logic in_leg, in_high;
    route_e plain;

    assign in_leg  = (addr >= LEG_BASE)  && (addr < LEG_END);
    assign in_high = (addr >= HIGH_BASE) && (addr < HIGH_END);

    // view seen outside management mode
    always_comb begin
        plain = RT_PASS;
        if (in_leg)
            plain = (open && !hi_en) ? RT_LOWMEM : RT_LEGACY;
        else if (in_high)
            plain = (open && hi_en) ? RT_HIGHAL : RT_PASS;
    end

    always_comb begin
        route = plain;
        if (in_tseg)
            route = smm ? RT_TSEG : RT_SINK;
        else if (smm && glb && in_leg && !hi_en)
            route = RT_LOWMEM;
        else if (smm && glb && in_high && hi_en)
            route = RT_HIGHAL;
    end

    // R9
    sink_only_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (route == RT_SINK) |-> (!smm && in_tseg));
    // R8
    tseg_only_smm_chk: assert property (@(posedge clk) disable iff (rst)
        (route == RT_TSEG) |-> smm);
    // R4
    high_needs_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (route == RT_HIGHAL) |-> (hi_en && in_high));
    // R5
    closed_no_dram_chk: assert property (@(posedge clk) disable iff (rst)
        (!smm && !open) |-> (route != RT_LOWMEM && route != RT_HIGHAL));

endmodule

// File: rtl/smm_window_ctrl.sv
module smm_window_ctrl
    import smm_win_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] TOP_LOW_MEM = 32'h8000_0000,
    parameter int unsigned       EXT_MB      = 16
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_wr,
    input  logic [REG_BYTES-1:0]   cfg_be,
    input  logic [REG_BYTES*8-1:0] cfg_wdata,
    output logic [REG_BYTES*8-1:0] cfg_rdata,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic                   acc_smm,
    output logic [2:0]             acc_route
);
    logic [REG_BYTES*8-1:0] regs;
    winctl_t ctl;
    winext_t ext;
    logic    in_tseg;
    route_e  route;

    smm_cfg_regs u_regs (
        .clk(clk), .rst(rst), .wr(cfg_wr), .be(cfg_be),
        .wdata(cfg_wdata), .regs(regs)
    );

    assign ctl = winctl_t'(regs[7:0]);
    assign ext = winext_t'(regs[15:8]);

    smm_tseg_window #(
        .ADDR_W(ADDR_W), .TOP_LOW_MEM(TOP_LOW_MEM), .EXT_MB(EXT_MB)
    ) u_tseg (
        .clk(clk), .rst(rst), .glb(ctl.glb), .tseg_en(ext.tseg_en),
        .sz_code(ext.sz_code), .addr(acc_addr), .in_tseg(in_tseg)
    );

    smm_route_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst(rst), .glb(ctl.glb), .open(ctl.open),
        .hi_en(ext.hi_en), .smm(acc_smm), .in_tseg(in_tseg),
        .addr(acc_addr), .route(route)
    );

    assign cfg_rdata = regs;
    assign acc_route = route;

    // R6
    low_dram_source_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_route == 3'd2) |-> !ext.hi_en);
    // R11
    code_range_chk: assert property (@(posedge clk) disable iff (rst)
        acc_route <= 3'd5);

endmodule

// File: tb/smm_window_ctrl_tb.sv
module smm_window_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] rdata, rdata_z;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_smm = 1'b0;
    logic [2:0]  route, route_z;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] TOP = 32'h8000_0000;
    localparam logic [31:0] LEG = 32'h000A_0000;
    localparam logic [31:0] HIA = 32'hFEDA_0000;

    always #2.5 clk = ~clk;

    smm_window_ctrl #(.EXT_MB(16)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata), .acc_addr(acc_addr),
        .acc_smm(acc_smm), .acc_route(route)
    );

    smm_window_ctrl #(.EXT_MB(0)) u_dut_z (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_z), .acc_addr(acc_addr),
        .acc_smm(acc_smm), .acc_route(route_z)
    );

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk); cfg_wr = 1'b0; cfg_be = 2'b00;
    endtask

    task automatic chk_reg(input logic [15:0] exp, input string tag);
        #1;
        n_chk++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s regs actual=%h expected=%h", tag, rdata, exp);
        end
    endtask

    task automatic chk_rt(input logic [31:0] a, input logic s,
                          input logic [2:0] exp, input string tag);
        acc_addr = a; acc_smm = s;
        #1;
        n_chk++;
        if (route !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h smm=%0b route actual=%0d expected=%0d",
                     tag, a, s, route, exp);
        end
    endtask

    task automatic chk_rt_z(input logic [31:0] a, input logic s,
                            input logic [2:0] exp, input string tag);
        acc_addr = a; acc_smm = s;
        #1;
        n_chk++;
        if (route_z !== exp) begin
            n_bad++;
            $display("FAIL %s zero-ext addr=%h route actual=%0d expected=%0d",
                     tag, a, route_z, exp);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk_reg(16'h0000, "R1");
        chk_rt(LEG, 1'b0, 3'd1, "R1");
    endtask

    task automatic t_masks();
        wr(2'b01, 16'h00FB);
        chk_reg(16'h0003, "R2");
        wr(2'b10, 16'hA5FF);
        chk_reg(16'hA503, "R2");
        wr(2'b00, 16'h0000);
        chk_reg(16'hA503, "R2");
        do_reset();
    endtask

    task automatic t_plain_open();
        wr(2'b11, 16'h0002);          // open, hi_en=0
        chk_rt(LEG, 1'b0, 3'd2, "R11");
        chk_rt(LEG + 32'h1FFFF, 1'b0, 3'd2, "R4");
        chk_rt(LEG + 32'h20000, 1'b0, 3'd0, "R4");
        chk_rt(HIA, 1'b0, 3'd0, "R4");
        wr(2'b10, 16'h0800);          // hi_en=1
        chk_rt(LEG, 1'b0, 3'd1, "R4");
        chk_rt(HIA, 1'b0, 3'd3, "R4");
        chk_rt(HIA + 32'h1FFFF, 1'b0, 3'd3, "R4");
    endtask

    task automatic t_plain_closed();
        wr(2'b11, 16'h0800);          // closed, hi_en=1
        chk_rt(LEG, 1'b0, 3'd1, "R5");
        chk_rt(HIA, 1'b0, 3'd0, "R5");
        wr(2'b11, 16'h0000);
        chk_rt(LEG, 1'b0, 3'd1, "R5");
    endtask

    task automatic t_smm_windows();
        wr(2'b11, 16'h0001);          // glb, hi_en=0
        chk_rt(LEG, 1'b1, 3'd2, "R6");
        chk_rt(HIA, 1'b1, 3'd0, "R6");
        wr(2'b10, 16'h0800);          // hi_en=1
        chk_rt(HIA, 1'b1, 3'd3, "R6");
        chk_rt(LEG, 1'b1, 3'd1, "R6");
        wr(2'b11, 16'h0000);          // glb clear
        chk_rt(LEG, 1'b1, 3'd1, "R6");
    endtask

    task automatic t_tseg_size(input logic [15:0] ext, input logic [31:0] sz,
                               input string tag);
        logic [31:0] base;
        base = TOP - sz;
        wr(2'b11, {ext[7:0], 8'h01});
        chk_rt(base, 1'b1, 3'd4, tag);
        chk_rt(base - 32'h1, 1'b1, 3'd0, "R8");
        chk_rt(TOP - 32'h1, 1'b1, 3'd4, "R8");
        chk_rt(TOP, 1'b1, 3'd0, "R8");
        chk_rt(base, 1'b0, 3'd5, "R9");
        chk_rt(TOP - 32'h1, 1'b0, 3'd5, "R9");
    endtask

    task automatic t_tseg();
        t_tseg_size(16'h0001, 32'h0010_0000, "R7");
        t_tseg_size(16'h0003, 32'h0020_0000, "R7");
        t_tseg_size(16'h0005, 32'h0080_0000, "R7");
        t_tseg_size(16'h0007, 32'h0100_0000, "R7");
        wr(2'b11, 16'h0100);          // TSEG enable without glb
        chk_rt(TOP - 32'h1, 1'b1, 3'd0, "R7");
        chk_rt(TOP - 32'h1, 1'b0, 3'd0, "R7");
    endtask

    task automatic t_zero_ext();
        wr(2'b11, 16'h0701);
        chk_rt_z(TOP - 32'h1, 1'b1, 3'd0, "R10");
        chk_rt_z(TOP - 32'h1, 1'b0, 3'd0, "R10");
        chk_rt(TOP - 32'h1, 1'b1, 3'd4, "R10");
        wr(2'b11, 16'h0101);
        chk_rt_z(TOP - 32'h1, 1'b1, 3'd4, "R10");
    endtask

    task automatic t_lock();
        do_reset();
        wr(2'b11, 16'h0807);          // glb, open, lock
        chk_reg(16'h0805, "R3");
        chk_rt(HIA, 1'b0, 3'd0, "R3");
        wr(2'b01, 16'h0002);
        chk_reg(16'h0805, "R3");
        wr(2'b10, 16'hFF00);
        chk_reg(16'hF805, "R3");
        chk_rt(TOP - 32'h1, 1'b1, 3'd0, "R3");
        do_reset();
        chk_reg(16'h0000, "R3");
        wr(2'b01, 16'h0002);
        chk_reg(16'h0002, "R3");
    endtask

    initial begin
        t_reset();
        t_masks();
        t_plain_open();
        t_plain_closed();
        t_smm_windows();
        t_tseg();
        t_zero_ext();
        t_lock();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule